// File: doc/BRIEF.md
# Renaming Reservation Stations with Result Bus

This block holds a small pool of reservation stations for one class of functional unit, plus the table that records, for each architectural register, which station will produce its next value. An instruction enters through the issue port with its opcode, destination, two source register numbers, the two values the register file currently holds for those sources, and an immediate. The block picks a free station, records the values of sources that are already final and the producing station's tag for sources that are still pending, and marks the destination register as owned by the new station. Renaming to station tags in this way removes write-after-write and write-after-read hazards.

Stations watch a result bus that carries a tag and a value. A waiting operand whose tag matches takes the value. A station whose two operands are both present is offered to the functional unit through a valid/ready dispatch port. The station stays allocated until its own result appears on the bus, and then it is released. When a result appears, the register whose owner is the broadcasting tag receives a write request on the register-file write port and its owner entry is cleared. The arithmetic units and the register storage are outside the block.

Top module: `tomasulo_rs_unit`

## Requirements
- R1: After reset all stations are free, `iss_ready` is 1, `disp_valid` is 0 and `rf_we` is 0.
- R2: An accepted issue takes the free station with the lowest index i, and that station's tag is i+1. Tags run from 1 to NUM_RS. Tag 0 means "no producer, value present".
- R3: `iss_ready` is 0 while every station is busy. An issue presented while `iss_ready` is 0 changes no station and no register owner entry.
- R4: At issue, a source whose register has owner tag 0 takes the supplied `iss_val*`. Any other source records the owner tag and waits.
- R5: If the owner of a source register broadcasts in the same cycle as the issue, the source takes `cdb_data` directly and does not wait.
- R6: A waiting operand whose recorded tag equals `cdb_tag` while `cdb_valid` is 1 takes `cdb_data` at that edge.
- R7: `disp_valid` is 1 when a station has both operands present and has not yet dispatched. The lowest such index is offered with its tag, opcode, both operand values and immediate, and the offer is held while `disp_ready` is 0.
- R8: A dispatched station stays busy until its tag is broadcast, and is free from the following cycle.
- R9: An accepted issue sets the owner of its destination register to the new tag. A later issue to the same register replaces the earlier owner.
- R10: A broadcast raises `rf_we` in the same cycle with `rf_waddr`/`rf_wdata`, and clears the owner entry, only for a register whose owner equals `cdb_tag`. A register renamed to a newer tag is not written.
- R11: When an issue names a destination in the same cycle that a broadcast clears that register's owner, the new issue's tag is the owner afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | Issue request |
| iss_ready | output | 1 | A free station exists |
| iss_op | input | OP_W | Opcode of issued instruction |
| iss_dst | input | REG_AW | Destination register |
| iss_src1 | input | REG_AW | First source register |
| iss_src2 | input | REG_AW | Second source register |
| iss_val1 | input | DATA_W | Register-file value of first source |
| iss_val2 | input | DATA_W | Register-file value of second source |
| iss_imm | input | DATA_W | Immediate or address field |
| cdb_valid | input | 1 | Result bus carries a result |
| cdb_tag | input | TAG_W | Tag of the producing station (nonzero) |
| cdb_data | input | DATA_W | Result value |
| disp_valid | output | 1 | A station is offered to the unit |
| disp_ready | input | 1 | Unit accepts the offer |
| disp_tag | output | TAG_W | Tag of offered station |
| disp_op | output | OP_W | Opcode of offered station |
| disp_vj | output | DATA_W | First operand value |
| disp_vk | output | DATA_W | Second operand value |
| disp_imm | output | DATA_W | Immediate or address field |
| rf_we | output | 1 | Register-file write request |
| rf_waddr | output | REG_AW | Register to write |
| rf_wdata | output | DATA_W | Value to write |

## Verification
The hardest cases to reach are the collisions between issue and broadcast in a single cycle: a source whose producer broadcasts while the consumer is issuing, and a destination that is renamed in the very cycle its old owner's result clears it. The stimulus first fills every station with a dependency chain that includes a rename of the same register. Dispatch is held back so that the stall and the ignored issue can be observed. Results are then released one at a time, and later issues are placed in the exact cycle of a chosen broadcast. The tag, the captured operand values and the register writes are compared against hand-derived expectations.

// File: rtl/rs_pkg.sv
// Package: shared types for the reservation-station block.
// Assumes: none; holds only the station lifecycle encoding.
package rs_pkg;
    typedef enum logic [1:0] {
        ST_FREE = 2'd0,   // station unallocated
        ST_WAIT = 2'd1,   // allocated, not yet dispatched
        ST_EXEC = 2'd2    // dispatched, waiting for own broadcast
    } st_state_e;
endpackage

// File: rtl/rs_pick.sv
// Module: lowest-index picker over a request vector.
// Assumes: N >= 1; IDX_W wide enough to hold N-1.
module rs_pick #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top so the lowest set bit wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/rs_station.sv
// Module: one reservation station entry.
// Holds opcode, two operand values with producer tags, and an immediate.
// Snoops the result bus and frees itself when its own tag is broadcast.
// Assumes: the alloc and take strobes come from pickers and are exclusive
// to one station; a tag value of zero means the operand is present.
module rs_station
    import rs_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int OP_W   = 3,
    parameter int TAG_W  = 3,
    parameter int MY_TAG = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_en,
    input  logic [OP_W-1:0]   in_op,
    input  logic [TAG_W-1:0]  in_qj,
    input  logic [DATA_W-1:0] in_vj,
    input  logic [TAG_W-1:0]  in_qk,
    input  logic [DATA_W-1:0] in_vk,
    input  logic [DATA_W-1:0] in_imm,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_data,
    input  logic              take_en,
    output logic              busy,
    output logic              ready,
    output logic [OP_W-1:0]   op_o,
    output logic [DATA_W-1:0] vj_o,
    output logic [DATA_W-1:0] vk_o,
    output logic [DATA_W-1:0] imm_o
);
    localparam logic [TAG_W-1:0] OWN_TAG = TAG_W'(MY_TAG);

    st_state_e         st_q;
    logic [TAG_W-1:0]  qj_q, qk_q;
    logic [DATA_W-1:0] vj_q, vk_q, imm_q;
    logic [OP_W-1:0]   op_q;
    logic              hit_j, hit_k, own_done;

    // Decode bus matches for each pending operand and for this station's own result.
    always_comb begin
        hit_j    = cdb_valid && (qj_q != '0) && (qj_q == cdb_tag);
        hit_k    = cdb_valid && (qk_q != '0) && (qk_q == cdb_tag);
        own_done = cdb_valid && (cdb_tag == OWN_TAG);
    end

    // Station lifecycle: allocate, capture operands, dispatch, free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_FREE;
            op_q  <= '0;
            qj_q  <= '0;
            qk_q  <= '0;
            vj_q  <= '0;
            vk_q  <= '0;
            imm_q <= '0;
        end else if (alloc_en) begin
            st_q  <= ST_WAIT;
            op_q  <= in_op;
            qj_q  <= in_qj;
            qk_q  <= in_qk;
            vj_q  <= in_vj;
            vk_q  <= in_vk;
            imm_q <= in_imm;
        end else begin
            case (st_q)
                ST_WAIT: begin
                    if (hit_j) begin
                        vj_q <= cdb_data;
                        qj_q <= '0;
                    end
                    if (hit_k) begin
                        vk_q <= cdb_data;
                        qk_q <= '0;
                    end
                    if (take_en) st_q <= ST_EXEC;
                end
                ST_EXEC: begin
                    if (own_done) st_q <= ST_FREE;
                end
                default: st_q <= ST_FREE;
            endcase
        end
    end

    // Status and field outputs toward picker and dispatch mux.
    always_comb begin
        busy  = (st_q != ST_FREE);
        ready = (st_q == ST_WAIT) && (qj_q == '0) && (qk_q == '0);
        op_o  = op_q;
        vj_o  = vj_q;
        vk_o  = vk_q;
        imm_o = imm_q;
    end
endmodule

// File: rtl/rs_reg_status.sv
// Module: register owner table (one producer tag per architectural register).
// Resolves issue-time sources to value or tag, with same-cycle bus bypass,
// and produces the register-file write for a broadcast whose tag owns a register.
// Assumes: a tag owns at most one register; set_tag is nonzero.
module rs_reg_status #(
    parameter int NUM_REGS = 8,
    parameter int REG_AW   = 3,
    parameter int TAG_W    = 3,
    parameter int DATA_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [REG_AW-1:0] set_reg,
    input  logic [TAG_W-1:0]  set_tag,
    input  logic [REG_AW-1:0] rd1_reg,
    input  logic [DATA_W-1:0] rd1_val,
    input  logic [REG_AW-1:0] rd2_reg,
    input  logic [DATA_W-1:0] rd2_val,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_data,
    output logic [TAG_W-1:0]  src1_q,
    output logic [DATA_W-1:0] src1_v,
    output logic [TAG_W-1:0]  src2_q,
    output logic [DATA_W-1:0] src2_v,
    output logic              wr_en,
    output logic [REG_AW-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    logic [TAG_W-1:0] owner_q [NUM_REGS];
    logic [TAG_W-1:0] own1, own2;

    // Source 1 resolution: file value, bypassed bus value, or pending tag.
    always_comb begin
        own1   = owner_q[rd1_reg];
        src1_q = own1;
        src1_v = rd1_val;
        if (own1 != '0 && cdb_valid && own1 == cdb_tag) begin
            src1_q = '0;
            src1_v = cdb_data;
        end
    end

    // Source 2 resolution, same rules as source 1.
    always_comb begin
        own2   = owner_q[rd2_reg];
        src2_q = own2;
        src2_v = rd2_val;
        if (own2 != '0 && cdb_valid && own2 == cdb_tag) begin
            src2_q = '0;
            src2_v = cdb_data;
        end
    end

    // Find the register (if any) owned by the broadcasting tag.
    always_comb begin
        wr_en   = 1'b0;
        wr_addr = '0;
        wr_data = cdb_data;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (cdb_valid && owner_q[r] != '0 && owner_q[r] == cdb_tag) begin
                wr_en   = 1'b1;
                wr_addr = REG_AW'(r);
            end
        end
    end

    // Owner update per register: a new issue wins over a clearing broadcast.
    genvar g;
    generate
        for (g = 0; g < NUM_REGS; g++) begin : g_owner
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    owner_q[g] <= '0;
                end else if (set_en && set_reg == REG_AW'(g)) begin
                    owner_q[g] <= set_tag;
                end else if (cdb_valid && owner_q[g] != '0 && owner_q[g] == cdb_tag) begin
                    owner_q[g] <= '0;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/tomasulo_rs_unit.sv
// Module: reservation-station pool with register owner table and result-bus snooping.
// Allocates the lowest free station at issue, renames destinations to station
// tags, offers the lowest ready station to the functional unit, and turns
// broadcasts into operand captures, station release and register writes.
// Assumes: the unit broadcasts a tag only for a dispatched station;
// cdb_tag is nonzero when cdb_valid is 1.
module tomasulo_rs_unit #(
    parameter int NUM_RS   = 4,
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 32,
    parameter int OP_W     = 3,
    parameter int TAG_W    = $clog2(NUM_RS + 1),
    parameter int REG_AW   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    output logic              iss_ready,
    input  logic [OP_W-1:0]   iss_op,
    input  logic [REG_AW-1:0] iss_dst,
    input  logic [REG_AW-1:0] iss_src1,
    input  logic [REG_AW-1:0] iss_src2,
    input  logic [DATA_W-1:0] iss_val1,
    input  logic [DATA_W-1:0] iss_val2,
    input  logic [DATA_W-1:0] iss_imm,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_data,
    output logic              disp_valid,
    input  logic              disp_ready,
    output logic [TAG_W-1:0]  disp_tag,
    output logic [OP_W-1:0]   disp_op,
    output logic [DATA_W-1:0] disp_vj,
    output logic [DATA_W-1:0] disp_vk,
    output logic [DATA_W-1:0] disp_imm,
    output logic              rf_we,
    output logic [REG_AW-1:0] rf_waddr,
    output logic [DATA_W-1:0] rf_wdata
);
    localparam int IDX_W = (NUM_RS > 1) ? $clog2(NUM_RS) : 1;

    logic [NUM_RS-1:0] busy_vec, ready_vec, alloc_vec, take_vec;
    logic [IDX_W-1:0]  free_idx, disp_idx;
    logic              any_free, any_ready, iss_fire, disp_fire;
    logic [TAG_W-1:0]  new_tag;
    logic [TAG_W-1:0]  s1_q, s2_q;
    logic [DATA_W-1:0] s1_v, s2_v;

    logic [OP_W-1:0]   st_op  [NUM_RS];
    logic [DATA_W-1:0] st_vj  [NUM_RS];
    logic [DATA_W-1:0] st_vk  [NUM_RS];
    logic [DATA_W-1:0] st_imm [NUM_RS];

    // Choose the lowest free station for allocation.
    rs_pick #(.N(NUM_RS), .IDX_W(IDX_W)) u_free_pick (
        .req   (~busy_vec),
        .found (any_free),
        .idx   (free_idx)
    );

    // Choose the lowest ready station for dispatch.
    rs_pick #(.N(NUM_RS), .IDX_W(IDX_W)) u_disp_pick (
        .req   (ready_vec),
        .found (any_ready),
        .idx   (disp_idx)
    );

    // Handshake qualifiers and the tag given to a new instruction.
    always_comb begin
        iss_ready  = any_free;
        iss_fire   = iss_valid && any_free;
        disp_valid = any_ready;
        disp_fire  = any_ready && disp_ready;
        new_tag    = TAG_W'(free_idx) + TAG_W'(1);
    end

    // Destination renaming and source resolution.
    rs_reg_status #(
        .NUM_REGS (NUM_REGS),
        .REG_AW   (REG_AW),
        .TAG_W    (TAG_W),
        .DATA_W   (DATA_W)
    ) u_regstat (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en    (iss_fire),
        .set_reg   (iss_dst),
        .set_tag   (new_tag),
        .rd1_reg   (iss_src1),
        .rd1_val   (iss_val1),
        .rd2_reg   (iss_src2),
        .rd2_val   (iss_val2),
        .cdb_valid (cdb_valid),
        .cdb_tag   (cdb_tag),
        .cdb_data  (cdb_data),
        .src1_q    (s1_q),
        .src1_v    (s1_v),
        .src2_q    (s2_q),
        .src2_v    (s2_v),
        .wr_en     (rf_we),
        .wr_addr   (rf_waddr),
        .wr_data   (rf_wdata)
    );

    // Station array; tag of station i is i+1.
    genvar g;
    generate
        for (g = 0; g < NUM_RS; g++) begin : g_st
            assign alloc_vec[g] = iss_fire  && (free_idx == IDX_W'(g));
            assign take_vec[g]  = disp_fire && (disp_idx == IDX_W'(g));

            rs_station #(
                .DATA_W (DATA_W),
                .OP_W   (OP_W),
                .TAG_W  (TAG_W),
                .MY_TAG (g + 1)
            ) u_station (
                .clk       (clk),
                .rst_n     (rst_n),
                .alloc_en  (alloc_vec[g]),
                .in_op     (iss_op),
                .in_qj     (s1_q),
                .in_vj     (s1_v),
                .in_qk     (s2_q),
                .in_vk     (s2_v),
                .in_imm    (iss_imm),
                .cdb_valid (cdb_valid),
                .cdb_tag   (cdb_tag),
                .cdb_data  (cdb_data),
                .take_en   (take_vec[g]),
                .busy      (busy_vec[g]),
                .ready     (ready_vec[g]),
                .op_o      (st_op[g]),
                .vj_o      (st_vj[g]),
                .vk_o      (st_vk[g]),
                .imm_o     (st_imm[g])
            );
        end
    endgenerate

    // Dispatch mux: present the selected station's fields.
    always_comb begin
        disp_tag = TAG_W'(disp_idx) + TAG_W'(1);
        disp_op  = '0;
        disp_vj  = '0;
        disp_vk  = '0;
        disp_imm = '0;
        for (int i = 0; i < NUM_RS; i++) begin
            if (disp_idx == IDX_W'(i)) begin
                disp_op  = st_op[i];
                disp_vj  = st_vj[i];
                disp_vk  = st_vk[i];
                disp_imm = st_imm[i];
            end
        end
    end
endmodule

// File: rtl/tomasulo_rs_unit_chk.sv
// Module: property checker bound to the reservation-station top.
// Assumes: it observes the station busy vector through the bind.
module tomasulo_rs_unit_chk #(
    parameter int NUM_RS = 4,
    parameter int TAG_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              iss_valid,
    input logic              iss_ready,
    input logic              cdb_valid,
    input logic              disp_valid,
    input logic              disp_ready,
    input logic [TAG_W-1:0]  disp_tag,
    input logic              rf_we,
    input logic [NUM_RS-1:0] busy_vec
);
    assert_full_stalls_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(busy_vec) == NUM_RS) |-> !iss_ready);

    assert_ignored_issue_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_ready && !cdb_valid) |=> ($countones(busy_vec) == NUM_RS));

    assert_alloc_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_ready && !cdb_valid) |=>
            ($countones(busy_vec) == $past($countones(busy_vec)) + 1));

    assert_release_only_on_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cdb_valid && !(iss_valid && iss_ready)) |=>
            ($countones(busy_vec) == $past($countones(busy_vec))));

    assert_offer_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && !disp_ready && !cdb_valid) |=> disp_valid);

    assert_tag_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> (disp_tag != '0 && disp_tag <= TAG_W'(NUM_RS)));

    assert_write_needs_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> cdb_valid);
endmodule

bind tomasulo_rs_unit tomasulo_rs_unit_chk #(.NUM_RS(NUM_RS), .TAG_W(TAG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .iss_valid  (iss_valid),
    .iss_ready  (iss_ready),
    .cdb_valid  (cdb_valid),
    .disp_valid (disp_valid),
    .disp_ready (disp_ready),
    .disp_tag   (disp_tag),
    .rf_we      (rf_we),
    .busy_vec   (busy_vec)
);

// File: tb/tomasulo_rs_unit_bench.sv
module tomasulo_rs_unit_bench;
    localparam int NUM_RS = 4, NUM_REGS = 8, DATA_W = 32, OP_W = 3;
    localparam int TAG_W = $clog2(NUM_RS + 1), REG_AW = $clog2(NUM_REGS);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic iss_valid = 1'b0, iss_ready;
    logic [OP_W-1:0]   iss_op = '0;
    logic [REG_AW-1:0] iss_dst = '0, iss_src1 = '0, iss_src2 = '0;
    logic [DATA_W-1:0] iss_val1 = '0, iss_val2 = '0, iss_imm = '0;
    logic cdb_valid = 1'b0;
    logic [TAG_W-1:0]  cdb_tag = '0;
    logic [DATA_W-1:0] cdb_data = '0;
    logic disp_valid, disp_ready = 1'b0;
    logic [TAG_W-1:0]  disp_tag;
    logic [OP_W-1:0]   disp_op;
    logic [DATA_W-1:0] disp_vj, disp_vk, disp_imm;
    logic rf_we;
    logic [REG_AW-1:0] rf_waddr;
    logic [DATA_W-1:0] rf_wdata;

    always #4 clk = ~clk;  // 125 MHz

    tomasulo_rs_unit #(.NUM_RS(NUM_RS), .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .OP_W(OP_W)) u_tomasulo_rs_unit (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
        .iss_op(iss_op), .iss_dst(iss_dst), .iss_src1(iss_src1), .iss_src2(iss_src2),
        .iss_val1(iss_val1), .iss_val2(iss_val2), .iss_imm(iss_imm),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
        .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_tag(disp_tag),
        .disp_op(disp_op), .disp_vj(disp_vj), .disp_vk(disp_vk), .disp_imm(disp_imm),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
    );

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [OP_W-1:0]   op;
        logic [DATA_W-1:0] vj, vk, imm;
    } disp_item_t;
    typedef struct packed {
        logic [REG_AW-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_item_t;

    disp_item_t exp_disp[$];
    wr_item_t   exp_wr[$];
    logic [DATA_W-1:0] rf_model [NUM_REGS];
    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
        iss_valid = 1'b0;
        cdb_valid = 1'b0;
    endtask

    task automatic set_issue(input int op, input int dst, input int s1, input int s2, input int imm);
        iss_valid = 1'b1;
        iss_op    = OP_W'(op);
        iss_dst   = REG_AW'(dst);
        iss_src1  = REG_AW'(s1);
        iss_src2  = REG_AW'(s2);
        iss_val1  = rf_model[s1];
        iss_val2  = rf_model[s2];
        iss_imm   = DATA_W'(imm);
    endtask

    task automatic set_cdb(input int tag, input int data);
        cdb_valid = 1'b1;
        cdb_tag   = TAG_W'(tag);
        cdb_data  = DATA_W'(data);
    endtask

    task automatic expect_disp(input int tag, input int op, input int vj, input int vk, input int imm);
        disp_item_t it;
        it.tag = TAG_W'(tag); it.op = OP_W'(op);
        it.vj = DATA_W'(vj); it.vk = DATA_W'(vk); it.imm = DATA_W'(imm);
        exp_disp.push_back(it);
    endtask

    task automatic expect_wr(input int addr, input int data);
        wr_item_t it;
        it.addr = REG_AW'(addr); it.data = DATA_W'(data);
        exp_wr.push_back(it);
    endtask

    // Monitor: compares accepted dispatches (R7) and register writes (R10) with the queues.
    always @(negedge clk) begin
        if (rst_n) begin
            if (disp_valid && disp_ready) begin
                if (exp_disp.size() == 0) begin
                    check("R7 unexpected dispatch tag", 64'(disp_tag), 64'hFFFF);
                end else begin
                    disp_item_t e;
                    e = exp_disp.pop_front();
                    check("R7 dispatch tag", 64'(disp_tag), 64'(e.tag));
                    check("R7 dispatch op", 64'(disp_op), 64'(e.op));
                    check("R6 dispatch vj", 64'(disp_vj), 64'(e.vj));
                    check("R6 dispatch vk", 64'(disp_vk), 64'(e.vk));
                    check("R7 dispatch imm", 64'(disp_imm), 64'(e.imm));
                end
            end
            if (rf_we) begin
                if (exp_wr.size() == 0) begin
                    check("R10 unexpected write addr", 64'(rf_waddr), 64'hFFFF);
                end else begin
                    wr_item_t w;
                    w = exp_wr.pop_front();
                    check("R10 write addr", 64'(rf_waddr), 64'(w.addr));
                    check("R10 write data", 64'(rf_wdata), 64'(w.data));
                end
                rf_model[rf_waddr] = rf_wdata;
            end
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        for (int r = 0; r < NUM_REGS; r++) rf_model[r] = DATA_W'(100 + r);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1 iss_ready", 64'(iss_ready), 1);
        check("R1 disp_valid", 64'(disp_valid), 0);
        check("R1 rf_we", 64'(rf_we), 0);
        @(posedge clk); #1;

        // Fill all stations; dispatch held back.
        set_issue(1, 1, 2, 3, 11); tick();
        check("R2 first tag", 64'(disp_tag), 1);
        check("R4 ready at issue", 64'(disp_valid), 1);
        set_issue(2, 4, 1, 2, 22); tick();    // waits on tag 1
        set_issue(3, 1, 4, 1, 33); tick();    // waits on 2 and 1; renames r1 (R9)
        set_issue(4, 5, 6, 7, 44); tick();
        check("R3 full stall", 64'(iss_ready), 0);
        check("R7 offer held lowest", 64'(disp_tag), 1);
        set_issue(5, 2, 0, 0, 55); tick();    // ignored while full
        check("R3 still full", 64'(iss_ready), 0);

        expect_disp(1, 1, 102, 103, 11);
        expect_disp(4, 4, 106, 107, 44);
        disp_ready = 1'b1;
        tick(); tick(); tick();
        check("R4 dependents wait", 64'(disp_valid), 0);
        check("R8 busy after dispatch", 64'(iss_ready), 0);

        // Tag 1 result: r1 renamed to tag 3, so no write (R10, R9).
        expect_disp(2, 2, 500, 102, 22);
        set_cdb(1, 500); tick(); tick();
        expect_wr(5, 600);
        set_cdb(4, 600); tick();
        expect_wr(4, 700);
        expect_disp(3, 3, 700, 500, 33);
        set_cdb(2, 700); tick(); tick();

        // R5 bypass: issue reads r1 while its owner (tag 3) broadcasts; tag 1 reused (R8, R2).
        expect_wr(1, 800);
        expect_disp(1, 6, 800, 800, 66);
        set_issue(6, 6, 1, 1, 66); set_cdb(3, 800); tick(); tick();

        // R9: r6 renamed to tag 2; its old owner tag 1 then writes nothing.
        set_issue(7, 6, 6, 0, 77); tick();
        check("R4 waits on producer", 64'(disp_valid), 0);
        expect_disp(2, 7, 900, 100, 77);
        set_cdb(1, 900); tick(); tick();

        // R11: issue renames r6 in the cycle its owner (tag 2) clears it; R3: r2 untouched by ignored issue.
        expect_wr(6, 1000);
        expect_disp(1, 5, 102, 100, 88);
        set_issue(5, 6, 2, 0, 88); set_cdb(2, 1000); tick(); tick();
        set_issue(6, 7, 6, 0, 99); tick();
        check("R11 new owner pending", 64'(disp_valid), 0);
        expect_wr(6, 1100);
        expect_disp(2, 6, 1100, 100, 99);
        set_cdb(1, 1100); tick(); tick();
        expect_wr(7, 1200);
        set_cdb(2, 1200); tick(); tick();

        check("R8 all free at end", 64'(iss_ready), 1);
        check("R7 no offer at end", 64'(disp_valid), 0);
        check("R7 dispatch queue drained", 64'(exp_disp.size()), 0);
        check("R10 write queue drained", 64'(exp_wr.size()), 0);
        summary();
    end
endmodule